// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Front End

This block is the host-facing register layer of a two-channel asynchronous serial controller. The host uses a 4-bit register address with separate read and write strobes. Each channel has four locations. The first is a mode location that reaches several mode bytes in turn through a pointer. The second returns line status on a read and takes the clock-select byte on a write. The third is a command location. The fourth is the data location for receive and transmit. A shared region at the top of the map holds a scratch register and a pair of set and clear locations that drive an inverted output port. The modem-control RTS lines of both channels are on that port.

The serial datapaths sit outside this block. They take the configuration bytes, the enable and clock-extend levels, the break level and the one-cycle control pulses that the command decoder produces. They return a status byte and a received byte for each channel. A build parameter selects the extended variant, which adds a third mode byte (MR0) that the pointer can reach. In the base variant that command code clears the transmitter clock-extend bit instead.

Top module: `dual_serial_regs`

## Requirements
- R1: After reset, each mode pointer selects MR1. All mode, clock-select and scratch bytes are 0x00. Receivers and transmitters are disabled. Clock-extend bits and break levels are 0. Every pulse output is low. The output port register is clear, so `port_pins_n` reads 0xFF.
- R2: The register offset is `bus_addr`. Offsets 0..3 belong to channel A and offsets 8..11 belong to channel B. Offset 0 of a channel is its mode location. A read or a write there accesses the byte that the pointer selects, and the same clock edge advances the pointer: MR0 goes to MR1, MR1 goes to MR2, and MR2 stays at MR2. An access to one channel leaves the other channel unchanged.
- R3: A command is a write to channel offset 2. Upper nibble 0x1 returns the pointer to MR1. With the extended variant (`EXT_VARIANT`=1), upper nibble 0xB moves the pointer to MR0 and leaves the clock-extend bits as they are. With the base variant, upper nibble 0xB clears the transmitter clock-extend bit and leaves the pointer as it is, and MR0 stays 0x00.
- R4: Command bit 0 enables the transmitter and bit 1 disables it. Bit 2 enables the receiver and bit 3 disables it. When a command sets both the enable bit and the disable bit of one direction, the disable takes effect.
- R5: Upper nibble 0x2 pulses `rx_rst_pulse` and 0x3 pulses `tx_rst_pulse`. Each pulse is high for exactly the one cycle after the write edge. The reset also disables that direction, unless the same command byte sets that direction's enable bit, in which case the direction ends up enabled.
- R6: Upper nibble 0x4 pulses `err_clr_pulse` and 0x5 pulses `brk_clr_pulse`, each for one cycle. Upper nibble 0x6 sets `break_hold` and 0x7 clears it.
- R7: Upper nibbles 0x8 and 0x9 set and clear `rx_ext`. Upper nibble 0xA sets `tx_ext`. Upper nibbles 0x0 and 0xC..0xF change neither the pointer nor any level output.
- R8: A write to channel offset 1 stores the whole byte as that channel's `cfg_clksel`. The receiver rate code is bits 7:4 and the transmitter rate code is bits 3:0. A read at offset 1 returns that channel's `chan_status` input.
- R9: A write to channel offset 3 loads `tx_byte` and pulses `tx_push` for the following cycle. A read at channel offset 3 returns `chan_rxbyte` and pulses `rx_pop` for the following cycle.
- R10: A write to offset 14 sets each output port bit whose data bit is 1. A write to offset 15 clears each such bit. `port_pins_n` is the inverse of that register, so bit 0 drives channel A RTS active-low and bit 1 drives channel B RTS active-low.
- R11: Offset 12 is a scratch byte that reads back the last value written to it.
- R12: Read data is registered. `bus_rdata` holds the value and `bus_rvalid` is high in the cycle after the read strobe. Offsets 2, 4..7, 10, 13, 14 and 15 read as 0x00. Writes to offsets 4..7 and 13 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| chan_status | input | 2x8 | Line status per channel |
| chan_rxbyte | input | 2x8 | Received byte per channel |
| cfg_mode0 | output | 2x8 | MR0 per channel (extended variant) |
| cfg_mode1 | output | 2x8 | MR1 per channel |
| cfg_mode2 | output | 2x8 | MR2 per channel |
| cfg_clksel | output | 2x8 | Clock-select byte per channel |
| tx_byte | output | 2x8 | Byte to transmit per channel |
| tx_push | output | 2 | Transmit load pulse per channel |
| rx_pop | output | 2 | Receive take pulse per channel |
| rx_enable | output | 2 | Receiver enabled |
| tx_enable | output | 2 | Transmitter enabled |
| rx_ext | output | 2 | Receiver clock-extend bit |
| tx_ext | output | 2 | Transmitter clock-extend bit |
| break_hold | output | 2 | Send break level |
| rx_rst_pulse | output | 2 | Receiver reset pulse |
| tx_rst_pulse | output | 2 | Transmitter reset pulse |
| err_clr_pulse | output | 2 | Error status clear pulse |
| brk_clr_pulse | output | 2 | Break status clear pulse |
| port_pins_n | output | 8 | Inverted output port pins |

## Verification
Two functions of one command byte can act in the same cycle: the nibble-coded action and the enable and disable bits in the low nibble. The bench provokes this with a byte that resets the receiver and also enables both directions. It checks that the reset pulse appears while the receiver finishes enabled. It also sends a byte that enables and disables the transmitter at once, and checks that the disable wins. A second instance built as the base variant receives the same command stream. Its transmitter clock-extend bit and its MR0 show how the shared 0xB code resolves differently in each variant.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int DW = 8;
  localparam int AW = 4;

  localparam logic [1:0] OFS_MODE = 2'd0;
  localparam logic [1:0] OFS_STAT_CLK = 2'd1;
  localparam logic [1:0] OFS_CMD = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;
  localparam logic [AW-1:0] ADDR_GPR = 4'hC;
  localparam logic [AW-1:0] ADDR_SET = 4'hE;
  localparam logic [AW-1:0] ADDR_CLR = 4'hF;

  typedef enum logic [1:0] {
    PTR_MR0 = 2'd0,
    PTR_MR1 = 2'd1,
    PTR_MR2 = 2'd2
  } mr_ptr_e;

  typedef struct packed {
    logic ptr_mr1;
    logic ptr_mr0;
    logic rx_rst;
    logic tx_rst;
    logic err_clr;
    logic brk_clr;
    logic brk_on;
    logic brk_off;
    logic rx_ext_set;
    logic rx_ext_clr;
    logic tx_ext_set;
    logic tx_ext_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [DW-1:0] c, input logic ext);
    cmd_t d;
    d = '0;
    d.tx_on = c[0];
    d.tx_off = c[1];
    d.rx_on = c[2];
    d.rx_off = c[3];
    case (c[7:4])
      4'h1: d.ptr_mr1 = 1'b1;
      4'h2: d.rx_rst = 1'b1;
      4'h3: d.tx_rst = 1'b1;
      4'h4: d.err_clr = 1'b1;
      4'h5: d.brk_clr = 1'b1;
      4'h6: d.brk_on = 1'b1;
      4'h7: d.brk_off = 1'b1;
      4'h8: d.rx_ext_set = 1'b1;
      4'h9: d.rx_ext_clr = 1'b1;
      4'hA: d.tx_ext_set = 1'b1;
      4'hB: begin
        if (ext) d.ptr_mr0 = 1'b1;
        else d.tx_ext_clr = 1'b1;
      end
      default: ;
    endcase
    return d;
  endfunction

  function automatic mr_ptr_e ptr_advance(input mr_ptr_e p);
    case (p)
      PTR_MR0: return PTR_MR1;
      default: return PTR_MR2;
    endcase
  endfunction

  // disable outranks enable, enable outranks an implied reset-disable
  function automatic logic en_next(input logic cur, input logic on, input logic off,
                                   input logic rst);
    if (off) return 1'b0;
    if (on) return 1'b1;
    if (rst) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/dsr_chan_ctrl.sv
module dsr_chan_ctrl
  import dsr_pkg::*;
#(
  parameter bit EXT_VARIANT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [1:0]    reg_ofs,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode0,
  output logic [DW-1:0] mode1,
  output logic [DW-1:0] mode2,
  output logic [DW-1:0] clksel,
  output logic [DW-1:0] mr_view,
  output logic [DW-1:0] tx_byte,
  output logic          tx_push,
  output logic          rx_pop,
  output logic          rx_en,
  output logic          tx_en,
  output logic          rx_ext,
  output logic          tx_ext,
  output logic          brk_hold,
  output logic          rx_rst_p,
  output logic          tx_rst_p,
  output logic          err_clr_p,
  output logic          brk_clr_p
);
  mr_ptr_e ptr;
  cmd_t    cmd;

  // named access events
  logic mr_acc, mr_wr, cmd_wr, csr_wr, txd_wr, rxd_rd;
  assign mr_acc = sel && (wr || rd) && (reg_ofs == OFS_MODE);
  assign mr_wr  = sel && wr && (reg_ofs == OFS_MODE);
  assign cmd_wr = sel && wr && (reg_ofs == OFS_CMD);
  assign csr_wr = sel && wr && (reg_ofs == OFS_STAT_CLK);
  assign txd_wr = sel && wr && (reg_ofs == OFS_DATA);
  assign rxd_rd = sel && rd && (reg_ofs == OFS_DATA);
  assign cmd    = decode_cmd(wdata, EXT_VARIANT);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= PTR_MR1;
    else if (cmd_wr && cmd.ptr_mr1) ptr <= PTR_MR1;
    else if (cmd_wr && cmd.ptr_mr0) ptr <= PTR_MR0;
    else if (mr_acc) ptr <= ptr_advance(ptr);
  end

  generate
    if (EXT_VARIANT) begin : g_mr0
      always_ff @(posedge clk) begin
        if (!rst_n) mode0 <= '0;
        else if (mr_wr && ptr == PTR_MR0) mode0 <= wdata;
      end
    end else begin : g_no_mr0
      assign mode0 = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode1  <= '0;
      mode2  <= '0;
      clksel <= '0;
      tx_byte <= '0;
    end else begin
      if (mr_wr && ptr == PTR_MR1) mode1 <= wdata;
      if (mr_wr && ptr == PTR_MR2) mode2 <= wdata;
      if (csr_wr) clksel <= wdata;
      if (txd_wr) tx_byte <= wdata;
    end
  end

  always_comb begin
    case (ptr)
      PTR_MR0: mr_view = mode0;
      PTR_MR1: mr_view = mode1;
      default: mr_view = mode2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
      rx_ext <= 1'b0;
      tx_ext <= 1'b0;
      brk_hold <= 1'b0;
    end else if (cmd_wr) begin
      rx_en <= en_next(rx_en, cmd.rx_on, cmd.rx_off, cmd.rx_rst);
      tx_en <= en_next(tx_en, cmd.tx_on, cmd.tx_off, cmd.tx_rst);
      if (cmd.rx_ext_set) rx_ext <= 1'b1;
      if (cmd.rx_ext_clr) rx_ext <= 1'b0;
      if (cmd.tx_ext_set) tx_ext <= 1'b1;
      if (cmd.tx_ext_clr) tx_ext <= 1'b0;
      if (cmd.brk_on) brk_hold <= 1'b1;
      if (cmd.brk_off) brk_hold <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rst_p <= 1'b0;
      tx_rst_p <= 1'b0;
      err_clr_p <= 1'b0;
      brk_clr_p <= 1'b0;
      tx_push <= 1'b0;
      rx_pop <= 1'b0;
    end else begin
      rx_rst_p <= cmd_wr && cmd.rx_rst;
      tx_rst_p <= cmd_wr && cmd.tx_rst;
      err_clr_p <= cmd_wr && cmd.err_clr;
      brk_clr_p <= cmd_wr && cmd.brk_clr;
      tx_push <= txd_wr;
      rx_pop <= rxd_rd;
    end
  end

  AST_MR2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == PTR_MR2 && !cmd_wr) |=> (ptr == PTR_MR2)); // R2
  AST_MR1_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[7:4] == 4'h1) |=> (ptr == PTR_MR1)); // R3
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[1]) |=> !tx_en); // R4
  AST_RXRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_p |-> $past(cmd_wr && wdata[7:4] == 4'h2)); // R5
  AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[7:4] == 4'h6) |=> brk_hold); // R6
  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(txd_wr)); // R9
endmodule

// File: rtl/dsr_port_bits.sv
module dsr_port_bits
  import dsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pins_n,
  output logic [DW-1:0] gpr
);
  logic [DW-1:0] opr;
  logic set_wr, clr_wr, gpr_wr;
  assign set_wr = wr && (addr == ADDR_SET);
  assign clr_wr = wr && (addr == ADDR_CLR);
  assign gpr_wr = wr && (addr == ADDR_GPR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opr <= '0;
      gpr <= '0;
    end else begin
      if (set_wr) opr <= opr | wdata;
      if (clr_wr) opr <= opr & ~wdata;
      if (gpr_wr) gpr <= wdata;
    end
  end

  assign pins_n = ~opr;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((~pins_n & $past(wdata)) == $past(wdata))); // R10
  AST_CLR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pins_n & $past(wdata)) == $past(wdata))); // R10
  AST_GPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gpr_wr |=> $stable(gpr)); // R11
endmodule

// File: rtl/dual_serial_regs.sv
module dual_serial_regs
  import dsr_pkg::*;
#(
  parameter bit EXT_VARIANT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 bus_rvalid,
  input  logic [1:0][7:0]      chan_status,
  input  logic [1:0][7:0]      chan_rxbyte,
  output logic [1:0][7:0]      cfg_mode0,
  output logic [1:0][7:0]      cfg_mode1,
  output logic [1:0][7:0]      cfg_mode2,
  output logic [1:0][7:0]      cfg_clksel,
  output logic [1:0][7:0]      tx_byte,
  output logic [1:0]           tx_push,
  output logic [1:0]           rx_pop,
  output logic [1:0]           rx_enable,
  output logic [1:0]           tx_enable,
  output logic [1:0]           rx_ext,
  output logic [1:0]           tx_ext,
  output logic [1:0]           break_hold,
  output logic [1:0]           rx_rst_pulse,
  output logic [1:0]           tx_rst_pulse,
  output logic [1:0]           err_clr_pulse,
  output logic [1:0]           brk_clr_pulse,
  output logic [7:0]           port_pins_n
);
  localparam int NCH = 2;

  logic [NCH-1:0]         chan_sel;
  logic [NCH-1:0][DW-1:0] mr_view;
  logic [DW-1:0]          gpr;
  logic [DW-1:0]          rd_value;
  logic                   ch_idx;

  assign ch_idx = bus_addr[3];

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      assign chan_sel[g] = !bus_addr[2] && (bus_addr[3] == g[0]);
      dsr_chan_ctrl #(.EXT_VARIANT(EXT_VARIANT)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (chan_sel[g]),
        .reg_ofs  (bus_addr[1:0]),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .mode0    (cfg_mode0[g]),
        .mode1    (cfg_mode1[g]),
        .mode2    (cfg_mode2[g]),
        .clksel   (cfg_clksel[g]),
        .mr_view  (mr_view[g]),
        .tx_byte  (tx_byte[g]),
        .tx_push  (tx_push[g]),
        .rx_pop   (rx_pop[g]),
        .rx_en    (rx_enable[g]),
        .tx_en    (tx_enable[g]),
        .rx_ext   (rx_ext[g]),
        .tx_ext   (tx_ext[g]),
        .brk_hold (break_hold[g]),
        .rx_rst_p (rx_rst_pulse[g]),
        .tx_rst_p (tx_rst_pulse[g]),
        .err_clr_p(err_clr_pulse[g]),
        .brk_clr_p(brk_clr_pulse[g])
      );
    end
  endgenerate

  dsr_port_bits u_port (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .pins_n(port_pins_n),
    .gpr   (gpr)
  );

  always_comb begin
    rd_value = '0;
    if (!bus_addr[2]) begin
      case (bus_addr[1:0])
        OFS_MODE:     rd_value = mr_view[ch_idx];
        OFS_STAT_CLK: rd_value = chan_status[ch_idx];
        OFS_DATA:     rd_value = chan_rxbyte[ch_idx];
        default:      rd_value = '0;
      endcase
    end else if (bus_addr == ADDR_GPR) begin
      rd_value = gpr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_value;
    end
  end

  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd)); // R12
  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_push)); // R2
endmodule

// File: tb/dual_serial_regs_bench.sv
module dual_serial_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [1:0][7:0] chan_status = '0, chan_rxbyte = '0;

  logic [7:0] bus_rdata, port_pins_n;
  logic bus_rvalid;
  logic [1:0][7:0] cfg_mode0, cfg_mode1, cfg_mode2, cfg_clksel, tx_byte;
  logic [1:0] tx_push, rx_pop, rx_enable, tx_enable, rx_ext, tx_ext, break_hold;
  logic [1:0] rx_rst_pulse, tx_rst_pulse, err_clr_pulse, brk_clr_pulse;

  logic [7:0] b_rdata, b_pins_n;
  logic b_rvalid;
  logic [1:0][7:0] b_mode0, b_mode1, b_mode2, b_clksel, b_tx_byte;
  logic [1:0] b_tx_push, b_rx_pop, b_rx_en, b_tx_en, b_rx_ext, b_tx_ext, b_brk;
  logic [1:0] b_rxrst, b_txrst, b_errclr, b_brkclr;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dual_serial_regs #(.EXT_VARIANT(1'b1)) u_dual_serial_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .chan_status(chan_status), .chan_rxbyte(chan_rxbyte), .cfg_mode0(cfg_mode0),
    .cfg_mode1(cfg_mode1), .cfg_mode2(cfg_mode2), .cfg_clksel(cfg_clksel),
    .tx_byte(tx_byte), .tx_push(tx_push), .rx_pop(rx_pop), .rx_enable(rx_enable),
    .tx_enable(tx_enable), .rx_ext(rx_ext), .tx_ext(tx_ext), .break_hold(break_hold),
    .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
    .err_clr_pulse(err_clr_pulse), .brk_clr_pulse(brk_clr_pulse),
    .port_pins_n(port_pins_n));

  dual_serial_regs #(.EXT_VARIANT(1'b0)) u_dual_serial_regs_base (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(b_rdata), .bus_rvalid(b_rvalid),
    .chan_status(chan_status), .chan_rxbyte(chan_rxbyte), .cfg_mode0(b_mode0),
    .cfg_mode1(b_mode1), .cfg_mode2(b_mode2), .cfg_clksel(b_clksel),
    .tx_byte(b_tx_byte), .tx_push(b_tx_push), .rx_pop(b_rx_pop), .rx_enable(b_rx_en),
    .tx_enable(b_tx_en), .rx_ext(b_rx_ext), .tx_ext(b_tx_ext), .break_hold(b_brk),
    .rx_rst_pulse(b_rxrst), .tx_rst_pulse(b_txrst),
    .err_clr_pulse(b_errclr), .brk_clr_pulse(b_brkclr),
    .port_pins_n(b_pins_n));

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares it later
  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected read data", {24'h0, bus_rdata}, 32'h0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata == e, t, {24'h0, bus_rdata}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(port_pins_n == 8'hFF, "R1 pins", {24'h0, port_pins_n}, 32'hFF);
    check(rx_enable == 2'b00 && tx_enable == 2'b00, "R1 enables",
          {28'h0, rx_enable, tx_enable}, 32'h0);
    check(rx_ext == 0 && tx_ext == 0 && break_hold == 0 && rx_rst_pulse == 0 &&
          tx_push == 0 && cfg_mode1 == 0 && cfg_clksel == 0, "R1 levels",
          {26'h0, rx_ext, tx_ext, break_hold}, 32'h0);

    // R1 pointer at MR1, R2 advance and stick
    wr(4'h0, 8'h11);
    check(cfg_mode1[0] == 8'h11, "R1 first mode write hits MR1", {24'h0, cfg_mode1[0]}, 32'h11);
    wr(4'h0, 8'h22);
    check(cfg_mode2[0] == 8'h22, "R2 second write hits MR2", {24'h0, cfg_mode2[0]}, 32'h22);
    wr(4'h0, 8'h33);
    check(cfg_mode2[0] == 8'h33 && cfg_mode1[0] == 8'h11, "R2 pointer stays on MR2",
          {16'h0, cfg_mode1[0], cfg_mode2[0]}, 32'h1133);
    rd(4'h0, 8'h33, "R2 read at MR2");
    wr(4'h2, 8'h10);
    rd(4'h0, 8'h11, "R3 cmd 0x1 back to MR1");
    rd(4'h0, 8'h33, "R2 read advances to MR2");

    // R3 extended: 0xB to MR0, MR0 access advances to MR1
    wr(4'h2, 8'hB0);
    wr(4'h0, 8'h44);
    check(cfg_mode0[0] == 8'h44, "R3 MR0 written", {24'h0, cfg_mode0[0]}, 32'h44);
    check(b_mode0[0] == 8'h00, "R3 base has no MR0", {24'h0, b_mode0[0]}, 32'h0);
    rd(4'h0, 8'h11, "R2 MR0 advances to MR1");

    // R3 / R7 extend bits
    wr(4'h2, 8'hA0);
    check(tx_ext[0] && b_tx_ext[0], "R7 tx ext set", {30'h0, tx_ext[0], b_tx_ext[0]}, 32'h3);
    wr(4'h2, 8'hB0);
    check(tx_ext[0] == 1'b1, "R3 ext variant keeps tx ext", {31'h0, tx_ext[0]}, 32'h1);
    check(b_tx_ext[0] == 1'b0, "R3 base clears tx ext", {31'h0, b_tx_ext[0]}, 32'h0);
    wr(4'h2, 8'h80);
    check(rx_ext[0] == 1'b1, "R7 rx ext set", {31'h0, rx_ext[0]}, 32'h1);
    wr(4'h2, 8'h90);
    check(rx_ext[0] == 1'b0, "R7 rx ext clear", {31'h0, rx_ext[0]}, 32'h0);

    // R4 enables
    wr(4'h2, 8'h05);
    check(rx_enable[0] && tx_enable[0], "R4 enable both", {30'h0, rx_enable[0], tx_enable[0]}, 32'h3);
    wr(4'h2, 8'h03);
    check(!tx_enable[0] && rx_enable[0], "R4 disable wins", {30'h0, rx_enable[0], tx_enable[0]}, 32'h2);
    wr(4'h2, 8'h0A);
    check(!rx_enable[0], "R4 rx disable", {31'h0, rx_enable[0]}, 32'h0);

    // R5 reset pulse together with enable bits in one byte
    wr(4'h2, 8'h25);
    check(rx_rst_pulse == 2'b01 && rx_enable[0] && tx_enable[0], "R5 reset plus enable",
          {28'h0, rx_rst_pulse, rx_enable[0], tx_enable[0]}, 32'h7);
    @(negedge clk);
    check(rx_rst_pulse == 2'b00, "R5 pulse one cycle", {30'h0, rx_rst_pulse}, 32'h0);
    wr(4'h2, 8'h30);
    check(tx_rst_pulse[0] && !tx_enable[0] && rx_enable[0], "R5 tx reset disables",
          {29'h0, tx_rst_pulse[0], tx_enable[0], rx_enable[0]}, 32'h5);

    // R6
    wr(4'h2, 8'h40);
    check(err_clr_pulse == 2'b01, "R6 error clear pulse", {30'h0, err_clr_pulse}, 32'h1);
    wr(4'h2, 8'h50);
    check(brk_clr_pulse == 2'b01 && err_clr_pulse == 0, "R6 break clear pulse",
          {28'h0, brk_clr_pulse, err_clr_pulse}, 32'h4);
    wr(4'h2, 8'h60);
    check(break_hold[0], "R6 break start", {31'h0, break_hold[0]}, 32'h1);
    wr(4'h2, 8'h70);
    check(!break_hold[0], "R6 break stop", {31'h0, break_hold[0]}, 32'h0);

    // R7 no-op nibble
    wr(4'h2, 8'hF0);
    check(tx_ext[0] && rx_enable[0] && !break_hold[0], "R7 nibble F no change",
          {29'h0, tx_ext[0], rx_enable[0], break_hold[0]}, 32'h6);
    rd(4'h0, 8'h44, "R7 nibble F keeps pointer at MR0");

    // R2 channel B isolation
    wr(4'hA, 8'h05);
    check(rx_enable == 2'b11 && tx_enable == 2'b10, "R2 channel B command",
          {28'h0, rx_enable, tx_enable}, 32'hE);

    // R8
    wr(4'h1, 8'h5C);
    wr(4'h9, 8'h3A);
    check(cfg_clksel[0] == 8'h5C && cfg_clksel[1] == 8'h3A, "R8 clock select",
          {16'h0, cfg_clksel[0], cfg_clksel[1]}, 32'h5C3A);
    chan_status = {8'h96, 8'hA5};
    rd(4'h1, 8'hA5, "R8 status A");
    rd(4'h9, 8'h96, "R8 status B");

    // R9
    wr(4'h3, 8'h7E);
    check(tx_byte[0] == 8'h7E && tx_push == 2'b01, "R9 tx load A",
          {22'h0, tx_push, tx_byte[0]}, 32'h17E);
    @(negedge clk);
    check(tx_push == 2'b00, "R9 tx push one cycle", {30'h0, tx_push}, 32'h0);
    wr(4'hB, 8'h81);
    check(tx_byte[1] == 8'h81 && tx_push == 2'b10, "R9 tx load B",
          {22'h0, tx_push, tx_byte[1]}, 32'h281);
    chan_rxbyte = {8'hC3, 8'h3C};
    rd(4'h3, 8'h3C, "R9 rx byte A");
    check(rx_pop == 2'b01, "R9 rx pop A", {30'h0, rx_pop}, 32'h1);
    rd(4'hB, 8'hC3, "R9 rx byte B");
    check(rx_pop == 2'b10, "R9 rx pop B", {30'h0, rx_pop}, 32'h2);

    // R10
    wr(4'hE, 8'h03);
    check(port_pins_n == 8'hFC, "R10 set RTS A and B", {24'h0, port_pins_n}, 32'hFC);
    wr(4'hF, 8'h01);
    check(port_pins_n == 8'hFD, "R10 clear RTS A", {24'h0, port_pins_n}, 32'hFD);
    wr(4'hE, 8'h80);
    check(port_pins_n == 8'h7D, "R10 set keeps others", {24'h0, port_pins_n}, 32'h7D);

    // R11
    wr(4'hC, 8'h5A);
    rd(4'hC, 8'h5A, "R11 scratch readback");

    // R12
    wr(4'h5, 8'hFF);
    wr(4'hD, 8'hFF);
    check(port_pins_n == 8'h7D, "R12 unmapped write no pin change", {24'h0, port_pins_n}, 32'h7D);
    rd(4'hC, 8'h5A, "R12 unmapped write keeps scratch");
    rd(4'h5, 8'h00, "R12 unmapped reads zero");
    rd(4'h2, 8'h00, "R12 command offset reads zero");
    rd(4'hE, 8'h00, "R12 set offset reads zero");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12 all reads returned", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule